// File: doc/BRIEF.md
# Fractional Microsecond Tick Prescaler

This block turns a fast reference clock into a steady one-microsecond time base. The reference does not have to be a whole multiple of 1 MHz. A 16-bit ratio word describes the division as a small fraction built from two byte fields. A phase accumulator spreads the ticks so that their long-run average rate is exact, even when single tick intervals differ by one reference cycle.

Each tick is a one-cycle pulse on an output pin and advances a free-running microsecond counter. A small register port reads the counter, reads and writes the ratio word, and sets a hold control. While hold is set, both the counter and the fractional phase stay where they are. Software selects the ratio word that matches the board's reference frequency. Two examples: 0x000B for a 12 MHz reference, and 0x045F for a 19.2 MHz reference (96 cycles per 5 ticks).

Top module: `usp_prescaler`

## Requirements
- R1: After a synchronous active-low reset, the ratio word reads 0x000B, the hold bit reads 0, the counter reads 0 and the tick output is low.
- R2: The ratio word holds the divisor field N in bits [7:0] and the multiplier field M in bits [15:8]. Each field encodes its value plus one. Every enabled reference cycle adds M+1 to a phase. When the phase reaches N+1 or more, N+1 is subtracted and a tick is produced, so there are M+1 ticks in every N+1 cycles. For example, 0x043F gives exactly 5 ticks in 64 cycles.
- R3: With M=0 the ticks are evenly spaced, one every N+1 cycles. A ratio of 0x0000 gives a tick on every cycle.
- R4: Each tick raises the tick output for one cycle. The counter has already advanced by exactly one when the tick output is first seen high. With no tick, the counter does not change.
- R5: The counter is CNT_W bits wide (32 by default). It wraps from all ones to zero with no flag.
- R6: While the hold bit is 1, no ticks are produced and both the counter and the phase keep their values. After hold is released, ticks continue from the phase that was kept.
- R7: Writing the ratio word clears the phase to zero, whether or not hold is set. The new ratio then starts from a clean phase. The ratio word reads back as it was written.
- R8: If M is greater than N, a tick is produced on every enabled cycle.
- R9: The register offsets are 0x10 for the counter (read-only; writes to it have no effect), 0x14 for the ratio word, and 0x4C for the hold control (bit 0). Reads of any other offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr (combinational) |
| tick_o | output | 1 | One-cycle pulse per microsecond tick |

## Verification
The hardest event to reach from the ports is the counter wrap, because the counter cannot be written. At full width it would need billions of ticks. The bench therefore builds the block with a 12-bit counter and sets the ratio to one tick per cycle, which reaches the all-ones-to-zero step within a few thousand cycles. Phase carry-over across hold periods and ratio rewrites comes from random interleaving of hold toggles, ratio writes with fractional values, and stray writes. Every cycle of this is compared against a phase model in the bench.

// File: rtl/usp_pkg.sv
// Shared constants and types for the microsecond prescaler.
// Assumes byte offsets on the register port and an 8-bit field width.
package usp_pkg;
    localparam int FIELD_W = 8;
    localparam int RATIO_W = 2 * FIELD_W;

    localparam logic [7:0] OFS_COUNT = 8'h10;
    localparam logic [7:0] OFS_RATIO = 8'h14;
    localparam logic [7:0] OFS_HOLD  = 8'h4C;

    localparam logic [RATIO_W-1:0] RATIO_RST = 16'h000B;

    // Upper byte: multiplier field (M), lower byte: divisor field (N).
    typedef struct packed {
        logic [FIELD_W-1:0] mul;
        logic [FIELD_W-1:0] div;
    } ratio_t;
endpackage

// File: rtl/usp_regs.sv
// Register port: ratio word, hold bit and the read multiplexer.
// Assumes a single-cycle write strobe and a combinational read path.
module usp_regs
    import usp_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CNT_W-1:0]  count,
    output ratio_t            ratio,
    output logic              hold,
    output logic              ratio_wr,
    output logic [DATA_W-1:0] rdata
);
    logic sel_ratio, sel_hold, sel_count;

    // Decode the three mapped offsets.
    always_comb begin
        sel_count = (addr == ADDR_W'(OFS_COUNT));
        sel_ratio = (addr == ADDR_W'(OFS_RATIO));
        sel_hold  = (addr == ADDR_W'(OFS_HOLD));
        ratio_wr  = wr && sel_ratio;
    end

    // Storage for the ratio word and the hold bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ratio <= RATIO_RST;
            hold  <= 1'b0;
        end else begin
            if (ratio_wr)
                ratio <= wdata[RATIO_W-1:0];
            if (wr && sel_hold)
                hold <= wdata[0];
        end
    end

    // Read multiplexer, zero-extending narrow fields.
    always_comb begin
        rdata = '0;
        if (sel_count)
            rdata[CNT_W-1:0] = count;
        else if (sel_ratio)
            rdata[RATIO_W-1:0] = ratio;
        else if (sel_hold)
            rdata[0] = hold;
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (ratio == RATIO_RST && !hold));
endmodule

// File: rtl/usp_phase_accum.sv
// Fractional phase accumulator: adds M+1 each enabled cycle, and when the
// phase reaches N+1 it subtracts N+1 and signals a tick.
// Assumes the ratio changes only together with clear.
module usp_phase_accum
    import usp_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  ratio_t ratio,
    input  logic   hold,
    input  logic   clear,
    output logic   hit,
    output logic   tick_o
);
    localparam int ACC_W = FIELD_W + 1;

    logic [ACC_W-1:0] phase_q, phase_d, step_amt, modulus, sum, rem;

    // Next phase and tick decision for this cycle.
    always_comb begin
        step_amt = {1'b0, ratio.mul} + ACC_W'(1);
        modulus  = {1'b0, ratio.div} + ACC_W'(1);
        sum      = phase_q + step_amt;
        rem      = sum - modulus;
        hit      = 1'b0;
        phase_d  = phase_q;
        if (clear) begin
            phase_d = '0;
        end else if (!hold) begin
            if (sum >= modulus) begin
                hit     = 1'b1;
                phase_d = (rem >= modulus) ? modulus - ACC_W'(1) : rem;
            end else begin
                phase_d = sum;
            end
        end
    end

    // Phase register and registered tick pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
            tick_o  <= 1'b0;
        end else begin
            phase_q <= phase_d;
            tick_o  <= hit;
        end
    end

    assert_phase_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q < ({1'b0, ratio.div} + ACC_W'(1)));
    assert_clear_phase_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (phase_q == '0 && !tick_o));
    assert_fast_ratio_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio.mul > ratio.div && !hold && !clear) |=> tick_o);
endmodule

// File: rtl/usp_counter.sv
// Free-running microsecond counter, advanced once per tick.
// Assumes step is at most one per cycle; wraps silently.
module usp_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [CNT_W-1:0] count
);
    // Count up by one on each step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (step)
            count <= count + CNT_W'(1);
    end

    assert_step_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> count == $past(count) + CNT_W'(1));
    assert_idle_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(count));
    assert_wrap_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && &count) |=> count == '0);
endmodule

// File: rtl/usp_prescaler.sv
// Top of the microsecond prescaler: register port, phase accumulator
// and counter. Assumes CNT_W <= DATA_W and ADDR_W >= 8.
module usp_prescaler
    import usp_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              tick_o
);
    ratio_t           ratio;
    logic             hold, ratio_wr, hit;
    logic [CNT_W-1:0] count;

    usp_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .count(count), .ratio(ratio), .hold(hold),
        .ratio_wr(ratio_wr), .rdata(reg_rdata)
    );

    usp_phase_accum u_accum (
        .clk(clk), .rst_n(rst_n), .ratio(ratio), .hold(hold),
        .clear(ratio_wr), .hit(hit), .tick_o(tick_o)
    );

    usp_counter #(.CNT_W(CNT_W)) u_count (
        .clk(clk), .rst_n(rst_n), .step(hit), .count(count)
    );

    assert_hold_freezes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (!tick_o && $stable(count)));
endmodule

// File: tb/test_usp_prescaler.sv
module test_usp_prescaler;
    localparam int CW   = 12;
    localparam int CMOD = 1 << CW;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0;
    logic [7:0]  addr = 8'h10;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        tick;

    int checks = 0;
    int fails  = 0;
    string cur_req = "R4";

    int unsigned m_ratio = 32'h000B, m_acc = 0, m_cnt = 0;
    bit m_tick = 1'b0, m_hold = 1'b0;

    always #10 clk = ~clk;

    usp_prescaler #(.ADDR_W(8), .DATA_W(32), .CNT_W(CW)) i_usp_prescaler (
        .clk(clk), .rst_n(rst_n), .reg_wr(wr), .reg_addr(addr),
        .reg_wdata(wdata), .reg_rdata(rdata), .tick_o(tick)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_read(logic [7:0] a);
        case (a)
            8'h10:   return m_cnt;
            8'h14:   return m_ratio;
            8'h4C:   return {31'd0, m_hold};
            default: return 32'd0;
        endcase
    endfunction

    // Model of one clock edge, written from R2..R9.
    task automatic model_edge();
        int unsigned n1 = (m_ratio & 255) + 1;
        int unsigned a1 = ((m_ratio >> 8) & 255) + 1;
        int unsigned s, r;
        bit hit = 1'b0;
        if (wr && addr == 8'h14) m_acc = 0;
        else if (!m_hold) begin
            s = m_acc + a1;
            if (s >= n1) begin
                hit = 1'b1;
                r = s - n1;
                if (r >= n1) r = n1 - 1;
                m_acc = r;
            end else m_acc = s;
        end
        if (hit) m_cnt = (m_cnt + 1) % CMOD;
        m_tick = hit;
        if (wr && addr == 8'h14) m_ratio = wdata & 32'hFFFF;
        if (wr && addr == 8'h4C) m_hold = wdata[0];
    endtask

    task automatic cyc();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check(cur_req, {31'd0, tick}, {31'd0, m_tick});
        if (!wr) check(cur_req, rdata, exp_read(addr));
    endtask

    task automatic idle(int n, logic [7:0] a);
        wr = 1'b0; addr = a;
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic wreg(logic [7:0] a, logic [31:0] d);
        wr = 1'b1; addr = a; wdata = d;
        cyc();
        wr = 1'b0; addr = 8'h10;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : stim
        int unsigned c0;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1: reset values
        check("R1", rdata, 32'd0);
        check("R1", {31'd0, tick}, 32'd0);
        addr = 8'h14; #1 check("R1", rdata, 32'h000B);
        addr = 8'h4C; #1 check("R1", rdata, 32'd0);
        addr = 8'h10;
        rst_n = 1'b1;

        cur_req = "R3"; idle(40, 8'h10);          // default: every 12 cycles

        cur_req = "R2"; wreg(8'h14, 32'h043F);
        c0 = m_cnt; idle(64, 8'h10);
        check("R2", rdata, (c0 + 5) % CMOD);       // exactly 5 ticks per 64 cycles
        wreg(8'h14, 32'h04BF); idle(400, 8'h10);

        cur_req = "R3"; wreg(8'h14, 32'h0000);
        c0 = m_cnt; idle(10, 8'h10);
        check("R3", rdata, (c0 + 10) % CMOD);

        cur_req = "R8"; wreg(8'h14, 32'h0503);
        c0 = m_cnt; idle(8, 8'h10);
        check("R8", rdata, (c0 + 8) % CMOD);

        cur_req = "R6"; wreg(8'h14, 32'h045F); idle(7, 8'h10);
        wreg(8'h4C, 32'd1);
        c0 = m_cnt; idle(30, 8'h10);
        check("R6", rdata, c0);
        wreg(8'h4C, 32'd0); idle(60, 8'h10);

        cur_req = "R7"; wreg(8'h4C, 32'd1);
        wreg(8'h14, 32'h0002);                     // write while held
        idle(3, 8'h14);
        check("R7", rdata, 32'h0002);
        wreg(8'h4C, 32'd0); idle(9, 8'h10);

        cur_req = "R9"; c0 = m_cnt;
        wreg(8'h4C, 32'd1);
        wreg(8'h10, 32'hFFFF_FFFF);                // counter is read-only
        idle(1, 8'h10); check("R9", rdata, c0);
        wreg(8'h20, 32'h1234); idle(1, 8'h20); check("R9", rdata, 32'd0);
        wreg(8'h4C, 32'd0);

        cur_req = "R4";
        for (int i = 0; i < 4000; i++) begin
            int unsigned p = $urandom_range(0, 99);
            if (p < 2) begin
                logic [31:0] v;
                case ($urandom_range(0, 3))
                    0: v = 32'h043F;
                    1: v = 32'h045F;
                    2: v = {16'd0, $urandom_range(0, 255)};
                    default: v = {16'd0, 16'($urandom())};
                endcase
                wreg(8'h14, v);
            end else if (p < 4) wreg(8'h4C, {31'd0, 1'($urandom())});
            else if (p < 5) wreg(8'h10, $urandom());
            else if (p < 6) wreg(8'($urandom()), $urandom());
            else begin
                logic [7:0] a;
                case ($urandom_range(0, 5))
                    0: a = 8'h14;
                    1: a = 8'h4C;
                    2: a = 8'($urandom());
                    default: a = 8'h10;
                endcase
                idle(1, a);
            end
        end

        cur_req = "R5"; wreg(8'h4C, 32'd0); wreg(8'h14, 32'h0000);
        while (m_cnt != CMOD - 1) idle(1, 8'h10);
        idle(1, 8'h10);
        check("R5", rdata, 32'd0);
        check("R5", {31'd0, tick}, 32'd1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule